// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends 8-bit or 9-bit words over a half-duplex synchronous serial line where another device owns the shift clock. The external clock arrives on a pin. The block brings it into the system clock domain with a flop synchronizer, finds its edges, and moves one bit per clock cycle onto the data pin, least significant bit first. Software-side logic writes words through a strobe and a byte bus. A holding stage sits in front of the shifter, so one word can wait while another is on the line.

A transmit-empty flag shows when the holding stage can take a word. When the transmit interrupt enable is set, the flag drives an interrupt output through logic with no flops, so the interrupt also works as a wake source when the system clock is stopped. A separate status output shows when the shifter has nothing left to send.

The transmitter runs only when all of these hold:
- the port is switched on;
- synchronous mode is selected;
- the clock-master select is off;
- transmit is enabled;
- both receive enables are clear.

Top module: `sst_top`

## Requirements
- R1: The transmitter is active only when `port_on`, `sync_sel` and `tx_on` are 1 and `clk_master`, `rx_once` and `rx_stream` are 0. In any other cycle, both storage stages are emptied and any frame in progress is abandoned. One cycle later, `tx_empty`=1, `shreg_empty`=1 and `sdo_oe`=0. Strobes that arrive while the transmitter is inactive are ignored.
- R2: Suppose a word is written (`wr_stb`=1 for one cycle) while both the shifter and the holding stage are empty. The word goes straight into the shifter. From the next cycle, `shreg_empty`=0, and `tx_empty` stays 1.
- R3: A word written while the shifter is busy and the holding stage is empty is held. From the next cycle, `tx_empty`=0. `tx_empty` only falls in the cycle after an accepted write.
- R4: A frame ends on the falling edge of the normalised clock that follows its last bit. At that point a held word moves into the shifter and `tx_empty` returns to 1 while `shreg_empty` stays 0. If no word is held, `shreg_empty` becomes 1.
- R5: A write that arrives while the holding stage is full, and no frame ends in that cycle, is dropped. The held word and every word after it are sent unchanged.
- R6: Bits go out least significant bit first. Each bit appears on `sdo` after a rising edge of the normalised clock, so the master can sample it on the following falling edge. A frame is 9 bits if `len9`=1 at the write, and 8 bits otherwise. The ninth bit is the value of `bit9_in` at the moment of the write.
- R7: The normalised clock is `sck_pin` XOR `sck_inv`. With `sck_inv`=0 the clock idles low. With `sck_inv`=1 it idles high and every edge has the opposite sense.
- R8: `tx_irq` is `tx_empty` AND `irq_en`, with no register in the path.
- R9: `sdo_oe`=1 exactly while the shifter holds a word. While the shifter is empty, `sdo`=1.
- R10: After reset, `tx_empty`=1, `shreg_empty`=1, `sdo_oe`=0 and `sdo`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_on | input | 1 | Serial port enable |
| sync_sel | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock-master select; must be 0 for slave transmit |
| tx_on | input | 1 | Transmit enable |
| rx_once | input | 1 | Single-receive enable; must be 0 |
| rx_stream | input | 1 | Continuous-receive enable; must be 0 |
| irq_en | input | 1 | Transmit interrupt enable |
| len9 | input | 1 | 9-bit frame select, taken at write |
| bit9_in | input | 1 | Ninth data bit, taken at write |
| sck_inv | input | 1 | Clock polarity: 1 means the clock idles high |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_byte | input | DATA_W | Data written with the strobe |
| sck_pin | input | 1 | External shift clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pin |
| tx_empty | output | 1 | Holding stage is free |
| tx_irq | output | 1 | Transmit interrupt |
| shreg_empty | output | 1 | Shifter has no bits left |

## Verification
The bench plays the clock master and reads each frame on the falling edges. Three failures show up as wrong data:
- A design that shifts on the wrong edge, or ignores the polarity bit, puts the idle 1 where bit 0 belongs.
- A design that reads the ninth bit at handoff instead of at the write sends the value that was changed after the write.
- A design that lets a third write overwrite the held word sends the wrong second frame.

Back-to-back writes test the flag: it must be 0 while the second word waits and 1 at the handoff, with the shifter still loaded. A design that sets the flag too early, or lets the shifter look empty at the handoff, fails there. Finally, each blocking enable is turned on in turn while a write arrives. A design with incomplete gating would take the word or drive the pin.

// File: rtl/sst_pkg.sv
package sst_pkg;
  function automatic logic tx_run(input logic port_on, input logic sync_sel,
                                  input logic clk_master, input logic tx_on,
                                  input logic rx_once, input logic rx_stream);
    return port_on & sync_sel & tx_on & ~clk_master & ~rx_once & ~rx_stream;
  endfunction

  function automatic int frame_len(input logic nine, input int data_w);
    return nine ? data_w + 1 : data_w;
  endfunction
endpackage

// File: rtl/sst_sck_sync.sv
module sst_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic sck_inv,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;
  logic            norm;

  assign norm = sck_pin ^ sck_inv;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= norm;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/sst_core.sv
module sst_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              len9,
  input  logic              bit9_in,
  input  logic              rise,
  input  logic              fall,
  output logic              sdo,
  output logic              busy,
  output logic              hold_full,
  output logic              done_evt
);
  import sst_pkg::*;
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_d, hold_q, hold_d, wr_word;
  logic [CNT_W-1:0]  left_q, left_d, hold_len_q, hold_len_d, wr_len;
  logic              busy_d, hold_full_d, dout_q, dout_d;

  assign wr_word  = {bit9_in & len9, wr_byte};
  assign wr_len   = CNT_W'(frame_len(len9, DATA_W));
  assign done_evt = run & busy & (left_q == '0) & fall;

  always_comb begin
    sh_d        = sh_q;
    left_d      = left_q;
    hold_d      = hold_q;
    hold_len_d  = hold_len_q;
    busy_d      = busy;
    hold_full_d = hold_full;
    dout_d      = dout_q;
    if (!run) begin
      busy_d      = 1'b0;
      hold_full_d = 1'b0;
      left_d      = '0;
      dout_d      = 1'b1;
    end else begin
      if (busy && (left_q != '0) && rise) begin
        dout_d = sh_q[0];
        sh_d   = sh_q >> 1;
        left_d = left_q - 1'b1;
      end
      if (done_evt) begin
        dout_d = 1'b1;
        if (hold_full) begin
          sh_d        = hold_q;
          left_d      = hold_len_q;
          hold_full_d = 1'b0;
        end else begin
          busy_d = 1'b0;
        end
      end
      if (wr_stb) begin
        if (!busy_d) begin
          sh_d   = wr_word;
          left_d = wr_len;
          busy_d = 1'b1;
        end else if (!hold_full_d) begin
          hold_d      = wr_word;
          hold_len_d  = wr_len;
          hold_full_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      left_q     <= '0;
      hold_q     <= '0;
      hold_len_q <= '0;
      busy       <= 1'b0;
      hold_full  <= 1'b0;
      dout_q     <= 1'b1;
    end else begin
      sh_q       <= sh_d;
      left_q     <= left_d;
      hold_q     <= hold_d;
      hold_len_q <= hold_len_d;
      busy       <= busy_d;
      hold_full  <= hold_full_d;
      dout_q     <= dout_d;
    end
  end

  assign sdo = dout_q;
endmodule

// File: rtl/sst_top.sv
module sst_top #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_on,
  input  logic              sync_sel,
  input  logic              clk_master,
  input  logic              tx_on,
  input  logic              rx_once,
  input  logic              rx_stream,
  input  logic              irq_en,
  input  logic              len9,
  input  logic              bit9_in,
  input  logic              sck_inv,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              sck_pin,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              tx_empty,
  output logic              tx_irq,
  output logic              shreg_empty
);
  import sst_pkg::*;

  logic run, rise, fall, busy, hold_full, done_evt;

  assign run = tx_run(port_on, sync_sel, clk_master, tx_on, rx_once, rx_stream);

  sst_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .sck_inv(sck_inv),
    .rise(rise), .fall(fall)
  );

  sst_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .len9(len9), .bit9_in(bit9_in), .rise(rise), .fall(fall),
    .sdo(sdo), .busy(busy), .hold_full(hold_full), .done_evt(done_evt)
  );

  assign sdo_oe      = busy;
  assign shreg_empty = ~busy;
  assign tx_empty    = ~hold_full;
  assign tx_irq      = tx_empty & irq_en;
endmodule

// File: rtl/sst_chk.sv
module sst_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic wr_stb,
  input logic tx_empty,
  input logic tx_irq,
  input logic shreg_empty,
  input logic sdo,
  input logic sdo_oe,
  input logic done_evt
);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |-> !tx_irq);
  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (shreg_empty && tx_empty && !sdo_oe));
  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shreg_empty |-> (sdo && !sdo_oe));
  // R4
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_empty) && $past(run)) |-> !shreg_empty);
  // R5
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tx_empty && wr_stb && !done_evt) |=> !tx_empty);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(wr_stb));
  // R2
  direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && shreg_empty && wr_stb) |=> (!shreg_empty && tx_empty));
endmodule

bind sst_top sst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .wr_stb(wr_stb), .tx_empty(tx_empty),
  .tx_irq(tx_irq), .shreg_empty(shreg_empty), .sdo(sdo), .sdo_oe(sdo_oe),
  .done_evt(done_evt)
);

// File: tb/sim_sst_top.sv
module sim_sst_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_on = 1'b1, sync_sel = 1'b1, clk_master = 1'b0, tx_on = 1'b1;
  logic rx_once = 1'b0, rx_stream = 1'b0, irq_en = 1'b0, len9 = 1'b0;
  logic bit9_in = 1'b0, sck_inv = 1'b0, wr_stb = 1'b0, nclk = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic sck_pin, sdo, sdo_oe, tx_empty, tx_irq, shreg_empty;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign sck_pin = nclk ^ sck_inv;

  sst_top u0 (.*);

  function automatic logic [8:0] exp_word(input logic nine, input logic b9, input logic [7:0] d);
    return {nine & b9, d};
  endfunction
  function automatic int exp_len(input logic nine);
    return nine ? 9 : 8;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d, input logic nine, input logic b9);
    @(negedge clk);
    wr_byte = d; len9 = nine; bit9_in = b9; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic recv(input int n, output logic [8:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      nclk = 1'b1; idle(6);
      got[i] = sdo;
      nclk = 1'b0; idle(6);
    end
  endtask

  initial begin
    logic [8:0] got;
    idle(3); rst_n = 1'b1; idle(2);
    // R10 reset state
    check("R10 tx_empty", tx_empty, 1);
    check("R10 shreg_empty", shreg_empty, 1);
    check("R10 sdo_oe", sdo_oe, 0);
    check("R10 sdo", sdo, 1);
    // R8 interrupt gating
    check("R8 irq off", tx_irq, 0);
    irq_en = 1'b1; #1;
    check("R8 irq on", tx_irq, 1);

    // R2 R3 R4 back-to-back words, R5 third write dropped
    write(8'hA5, 1'b0, 1'b0);
    check("R2 loaded", shreg_empty, 0);
    check("R2 flag", tx_empty, 1);
    check("R9 oe", sdo_oe, 1);
    write(8'h3C, 1'b1, 1'b1);
    check("R3 flag", tx_empty, 0);
    check("R8 irq low", tx_irq, 0);
    write(8'hFF, 1'b0, 1'b0);
    bit9_in = 1'b0;
    recv(8, got);
    check("R6 first", got, 9'h0A5);
    check("R4 flag", tx_empty, 1);
    check("R4 busy", shreg_empty, 0);
    recv(9, got);
    check("R5 R6 second", got, 9'h13C);
    check("R9 empty", shreg_empty, 1);
    check("R9 oe off", sdo_oe, 0);
    check("R9 sdo idle", sdo, 1);

    // R7 polarity high, 9-bit
    sck_inv = 1'b1; idle(6);
    write(8'h5A, 1'b1, 1'b1);
    recv(9, got);
    check("R7 inv", got, 9'h15A);
    sck_inv = 1'b0; idle(6);

    // R1 each blocking enable
    for (int k = 0; k < 6; k++) begin
      port_on = (k != 0); sync_sel = (k != 1); tx_on = (k != 2);
      clk_master = (k == 3); rx_once = (k == 4); rx_stream = (k == 5);
      write(8'h81, 1'b0, 1'b0);
      write(8'h42, 1'b0, 1'b0);
      check("R1 shreg", shreg_empty, 1);
      check("R1 flag", tx_empty, 1);
      check("R1 oe", sdo_oe, 0);
    end
    port_on = 1; sync_sel = 1; tx_on = 1; clk_master = 0; rx_once = 0; rx_stream = 0;
    // R1 abort mid-frame
    write(8'h00, 1'b0, 1'b0);
    write(8'h11, 1'b0, 1'b0);
    nclk = 1'b1; idle(6); nclk = 1'b0; idle(6);
    rx_stream = 1'b1; idle(2);
    check("R1 abort", {shreg_empty, tx_empty, sdo_oe}, 3'b110);
    rx_stream = 1'b0; idle(2);

    // random frames
    void'($urandom(32'd1234));
    for (int t = 0; t < 40; t++) begin
      logic [7:0] d0, d1;
      logic n0, n1, b0, b1, two;
      d0 = 8'($urandom); d1 = 8'($urandom);
      n0 = 1'($urandom); n1 = 1'($urandom);
      b0 = 1'($urandom); b1 = 1'($urandom);
      two = 1'($urandom);
      sck_inv = 1'($urandom); idle(6);
      write(d0, n0, b0);
      if (two) write(d1, n1, b1);
      bit9_in = ~bit9_in;
      recv(exp_len(n0), got);
      check("R6 rnd0", got, exp_word(n0, b0, d0));
      if (two) begin
        check("R4 rnd", {tx_empty, shreg_empty}, 2'b10);
        recv(exp_len(n1), got);
        check("R6 rnd1", got, exp_word(n1, b1, d1));
      end
      check("R9 rnd", shreg_empty, 1);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule